// File: doc/BRIEF.md
# Vertical Sync Detector with Frame-Aligned Layer Enables

This block sits between the raw horizontal and vertical sync inputs of an overlay display pipeline and the raster logic that follows. Both sync inputs are brought into the dot-clock domain through a short synchroniser chain. A programmable sense bit turns them into active-high levels. The block marks the start of every line with a one-cycle pulse, taken from whichever horizontal sync edge the raster logic is set to run from.

To find the start of a frame, the vertical sync level is sampled once per line at a chosen sampling point. That point is either the leading or the trailing horizontal sync edge. When all three edge-control bits are set, it is instead a fixed number of dot clocks after the leading edge. When the sampled level changes in the selected direction between two consecutive sampling points, the block emits a one-cycle frame-start pulse.

The block also gates three display-layer enables. A layer being switched off is dropped at once. A layer being switched on is held back until the next frame-start pulse, so that a layer always first appears at the top of a field.

A two-state machine controls the delayed sampling. **ST_WATCH** is the idle state and **ST_HOLDOFF** is the delay state.
- ST_WATCH→ST_HOLDOFF (*arm*): delayed mode is on and a leading horizontal edge is seen.
- ST_HOLDOFF→ST_HOLDOFF (*count*): the count is below the delay.
- ST_HOLDOFF→ST_WATCH (*fire*): the count reaches the delay, which is the sampling point.
- ST_HOLDOFF→ST_WATCH (*abort*): delayed mode is switched off before the count completes.

Top module: `osd_vsync_det`

## Requirements
- R1: While reset is asserted, and after it is released, `frame_start`, `line_start` and `disp_en` are 0. The sense bit, the three edge bits and all layer requests are cleared.
- R2: Configuration is written with `cfg_wr` and takes effect after that clock edge. A value of 0 on `cfg_sync_pol` means both sync inputs are active low; a value of 1 means they are active high. Each input passes through two flip-flops before it is used.
- R3: When `cfg_v_edge`=0, `frame_start` pulses if the previous sampled vertical level was inactive and the current one is active (leading edge). The pulse appears in the cycle after the sampling point.
- R4: When `cfg_v_edge`=1, `frame_start` pulses if the previous sampled vertical level was active and the current one is inactive (trailing edge).
- R5: Unless all three edge bits are 1, the sampling point depends on `cfg_h_samp`. A value of 0 selects the detected leading (inactive→active) horizontal edge; a value of 1 selects the trailing edge.
- R6: When `cfg_v_edge`, `cfg_h_samp` and `cfg_h_run` are all 1, the sampling point is 10 dot clocks after the cycle in which the leading horizontal edge is detected. Leading edges that arrive during that wait are ignored.
- R7: `line_start` pulses for one cycle on the trailing horizontal edge when `cfg_h_run`=0, and on the leading edge when `cfg_h_run`=1. An input change driven before clock edge k shows on `line_start` after edge k+2.
- R8: `frame_start` is never high in two consecutive cycles.
- R9: A `disp_en` bit whose request goes from 0 to 1 stays 0 until the next `frame_start`. It rises in the same cycle as that pulse.
- R10: A `disp_en` bit whose request is written to 0 is 0 from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Raw horizontal sync |
| vsync_in | input | 1 | Raw vertical sync |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sync_pol | input | 1 | Sync input sense (0 active low, 1 active high) |
| cfg_v_edge | input | 1 | Vertical edge to detect (0 leading, 1 trailing) |
| cfg_h_samp | input | 1 | Horizontal edge for vertical sampling (0 leading, 1 trailing) |
| cfg_h_run | input | 1 | Horizontal edge for line start (0 trailing, 1 leading) |
| cfg_layer_req | input | LAYERS | Requested layer enables |
| frame_start | output | 1 | One-cycle frame-start pulse |
| line_start | output | 1 | One-cycle line-start pulse |
| disp_en | output | LAYERS | Frame-aligned layer enables |

## Verification
The assertions assume that the horizontal period is longer than the sampling delay, so that a leading edge never falls inside a pending wait. They also assume that configuration is not written in the cycle that reset is released. The stimulus draws line lengths of 40 to 79 clocks and sync pulse widths of 4 to 11 clocks. It writes configuration only well after reset, and moves vertical sync transitions to random positions within a line. Every one of the sixteen combinations of the four control bits is run as its own segment.

// File: rtl/osd_vsync_pkg.sv
package osd_vsync_pkg;

    typedef enum logic [0:0] {
        ST_WATCH   = 1'b0,
        ST_HOLDOFF = 1'b1
    } samp_state_e;

    typedef struct packed {
        logic sync_pol;
        logic v_edge;
        logic h_samp;
        logic h_run;
    } sync_cfg_t;

endpackage

// File: rtl/osd_sync_level.sv
module osd_sync_level #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol,
    output logic act
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= raw;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], raw};
            end
        end
    endgenerate

    assign act = pol ? chain_q[STAGES-1] : ~chain_q[STAGES-1];

endmodule

// File: rtl/osd_vsync_sampler.sv
module osd_vsync_sampler
    import osd_vsync_pkg::*;
#(
    parameter int DLY_CLKS = 10
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      h_act,
    input  logic      v_act,
    input  sync_cfg_t cfg,
    output logic      frame_evt,
    output logic      frame_start,
    output logic      line_start
);
    localparam int CNT_W = $clog2(DLY_CLKS + 1);

    samp_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic h_d_q, vs_q, fs_q, ls_q;
    logic h_rise, h_fall, dly_mode, samp;

    assign h_rise   = h_act & ~h_d_q;
    assign h_fall   = ~h_act & h_d_q;
    assign dly_mode = cfg.v_edge & cfg.h_samp & cfg.h_run;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WATCH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_WATCH: begin
                cnt_d = '0;
                if (dly_mode && h_rise) begin
                    state_d = ST_HOLDOFF;
                    cnt_d   = CNT_W'(1);
                end
            end
            ST_HOLDOFF: begin
                if (!dly_mode || cnt_q == CNT_W'(DLY_CLKS)) begin
                    state_d = ST_WATCH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = ST_WATCH;
                cnt_d   = '0;
            end
        endcase
    end

    // sampling point and frame event
    always_comb begin
        if (dly_mode) samp = (state_q == ST_HOLDOFF) && (cnt_q == CNT_W'(DLY_CLKS));
        else          samp = cfg.h_samp ? h_fall : h_rise;
        frame_evt = samp & (cfg.v_edge ? (vs_q & ~v_act) : (~vs_q & v_act));
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_d_q <= 1'b0;
            vs_q  <= 1'b0;
            fs_q  <= 1'b0;
            ls_q  <= 1'b0;
        end else begin
            h_d_q <= h_act;
            if (samp) vs_q <= v_act;
            fs_q  <= frame_evt;
            ls_q  <= cfg.h_run ? h_rise : h_fall;
        end
    end

    assign frame_start = fs_q;
    assign line_start  = ls_q;

endmodule

// File: rtl/osd_layer_gate.sv
module osd_layer_gate #(
    parameter int LAYERS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAYERS-1:0] req,
    input  logic              frame_evt,
    output logic [LAYERS-1:0] en
);
    logic [LAYERS-1:0] armed_q;

    generate
        for (genvar i = 0; i < LAYERS; i++) begin : g_layer
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) armed_q[i] <= 1'b0;
                else        armed_q[i] <= req[i] & (armed_q[i] | frame_evt);
            end
            assign en[i] = req[i] & armed_q[i];
        end
    endgenerate

endmodule

// File: rtl/osd_vsync_det.sv
module osd_vsync_det
    import osd_vsync_pkg::*;
#(
    parameter int LAYERS      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int DLY_CLKS    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              cfg_wr,
    input  logic              cfg_sync_pol,
    input  logic              cfg_v_edge,
    input  logic              cfg_h_samp,
    input  logic              cfg_h_run,
    input  logic [LAYERS-1:0] cfg_layer_req,
    output logic              frame_start,
    output logic              line_start,
    output logic [LAYERS-1:0] disp_en
);
    sync_cfg_t         cfg_q;
    logic [LAYERS-1:0] req_q;
    logic              h_act, v_act, frame_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            req_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= '{sync_pol: cfg_sync_pol, v_edge: cfg_v_edge,
                       h_samp: cfg_h_samp, h_run: cfg_h_run};
            req_q <= cfg_layer_req;
        end
    end

    osd_sync_level #(.STAGES(SYNC_STAGES)) u_hsync (
        .clk(clk), .rst_n(rst_n), .raw(hsync_in), .pol(cfg_q.sync_pol), .act(h_act)
    );

    osd_sync_level #(.STAGES(SYNC_STAGES)) u_vsync (
        .clk(clk), .rst_n(rst_n), .raw(vsync_in), .pol(cfg_q.sync_pol), .act(v_act)
    );

    osd_vsync_sampler #(.DLY_CLKS(DLY_CLKS)) u_samp (
        .clk(clk), .rst_n(rst_n), .h_act(h_act), .v_act(v_act), .cfg(cfg_q),
        .frame_evt(frame_evt), .frame_start(frame_start), .line_start(line_start)
    );

    osd_layer_gate #(.LAYERS(LAYERS)) u_gate (
        .clk(clk), .rst_n(rst_n), .req(req_q), .frame_evt(frame_evt), .en(disp_en)
    );

endmodule

// File: rtl/osd_vsync_det_chk.sv
module osd_vsync_det_chk #(
    parameter int LAYERS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [LAYERS-1:0] cfg_layer_req,
    input logic              frame_start,
    input logic              line_start,
    input logic [LAYERS-1:0] disp_en
);
    // R1: outputs are quiet in the cycle after a reset cycle
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!frame_start && !line_start && disp_en == '0));

    // R7: line pulse lasts one cycle
    assert_line_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !line_start);

    // R8: frame pulse lasts one cycle
    assert_frame_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R9: an enable only rises together with a frame pulse
    assert_defer_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((disp_en & ~$past(disp_en)) != '0) |-> frame_start);

    // R10: a layer written off is off in the next cycle
    assert_drop_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> ((disp_en & ~$past(cfg_layer_req)) == '0));

endmodule

bind osd_vsync_det osd_vsync_det_chk #(.LAYERS(LAYERS)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_layer_req(cfg_layer_req),
    .frame_start(frame_start), .line_start(line_start), .disp_en(disp_en)
);

// File: tb/osd_vsync_det_tb_top.sv
module osd_vsync_det_tb_top;
    localparam int L   = 3;
    localparam int DLY = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hsync_in = 1'b1, vsync_in = 1'b1, cfg_wr = 1'b0;
    logic c_pol = 0, c_ve = 0, c_hs = 0, c_hr = 0;
    logic [L-1:0] c_req = '0;
    logic frame_start, line_start;
    logic [L-1:0] disp_en;

    int n_chk = 0, n_fail = 0;
    bit done = 0, run_chk = 0;

    always #4 clk = ~clk;

    osd_vsync_det #(.LAYERS(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .cfg_wr(cfg_wr), .cfg_sync_pol(c_pol), .cfg_v_edge(c_ve),
        .cfg_h_samp(c_hs), .cfg_h_run(c_hr), .cfg_layer_req(c_req),
        .frame_start(frame_start), .line_start(line_start), .disp_en(disp_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic norm(input logic raw, input logic pol);
        return pol ? raw : ~raw;
    endfunction

    function automatic logic dir_hit(input logic prev, input logic now, input logic trailing);
        return trailing ? (prev & ~now) : (~prev & now);
    endfunction

    // reference model, built from the requirements' timing
    logic m_pol, m_ve, m_hs, m_hr;
    logic [L-1:0] m_req, m_arm;
    logic m_h1, m_h2, m_v1, m_v2, m_hd, m_vs, m_fs, m_ls;
    int   m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_pol, m_ve, m_hs, m_hr} <= '0;
            m_req <= '0; m_arm <= '0;
            m_h1 <= 1; m_h2 <= 1; m_v1 <= 1; m_v2 <= 1;
            m_hd <= 0; m_vs <= 0; m_fs <= 0; m_ls <= 0; m_cnt <= 0;
        end else begin
            logic ha, va, hr, hf, dm, sp, ev;
            ha = norm(m_h2, m_pol);
            va = norm(m_v2, m_pol);
            hr = ha & ~m_hd;
            hf = ~ha & m_hd;
            dm = m_ve & m_hs & m_hr;
            sp = dm ? (m_cnt == DLY) : (m_hs ? hf : hr);
            ev = sp & dir_hit(m_vs, va, m_ve);
            if (!dm || m_cnt == DLY) m_cnt <= 0;
            else if (m_cnt != 0)     m_cnt <= m_cnt + 1;
            else if (hr)             m_cnt <= 1;
            m_h1 <= hsync_in; m_h2 <= m_h1;
            m_v1 <= vsync_in; m_v2 <= m_v1;
            m_hd <= ha;
            if (sp) m_vs <= va;
            m_fs  <= ev;
            m_ls  <= m_hr ? hr : hf;
            m_arm <= m_req & (m_arm | {L{ev}});
            if (cfg_wr) begin
                {m_pol, m_ve, m_hs, m_hr} <= {c_pol, c_ve, c_hs, c_hr};
                m_req <= c_req;
            end
        end
    end

    // per-cycle comparison away from the active edge
    logic prev_fs = 0;
    always @(negedge clk) begin
        if (run_chk) begin
            string ft;
            ft = (m_ve & m_hs & m_hr) ? "R6 R2" : (m_ve ? "R4 R5 R2" : "R3 R5 R2");
            chk(ft, frame_start, m_fs);
            chk("R7", line_start, m_ls);
            chk("R9 R10", disp_en, m_req & m_arm);
            if (frame_start) chk("R8", {31'd0, prev_fs}, 32'd0);
        end
        prev_fs = frame_start;
    end

    // sync waveform generator state
    int pos = 0, per = 60, wid = 6, lines_left = 4, v_off = 20;
    logic v_on = 0;

    task automatic step_sync();
        pos++;
        if (pos >= per) begin
            pos = 0;
            per = 40 + int'($urandom % 40);
            wid = 4 + int'($urandom % 8);
            lines_left--;
            if (lines_left == 0) begin
                lines_left = 2 + int'($urandom % 5);
                v_off = int'($urandom % 40);
            end
        end
        if (lines_left == 1 && pos == v_off) v_on = ~v_on;
        hsync_in = norm(pos < wid, c_pol);
        vsync_in = norm(v_on, c_pol);
    endtask

    task automatic write_cfg(input logic [3:0] c, input logic [L-1:0] r);
        @(negedge clk);
        {c_pol, c_ve, c_hs, c_hr} = c;
        c_req  = r;
        cfg_wr = 1;
        step_sync();
        @(negedge clk);
        cfg_wr = 0;
        step_sync();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ($urandom % 600 == 0) begin
                c_req = L'($urandom);
                cfg_wr = 1;
            end else cfg_wr = 0;
            step_sync();
        end
        @(negedge clk);
        cfg_wr = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        chk("R1", {frame_start, line_start, disp_en}, 0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk("R1", {frame_start, line_start, disp_en}, 0);
        run_chk = 1;

        // directed: layers requested on stay off until the first frame pulse (R9)
        write_cfg(4'b0000, 3'b111);
        chk("R9", disp_en, 0);
        begin
            int guard = 0;
            while (!frame_start && guard < 5000) begin
                chk("R9", disp_en, 0);
                @(negedge clk); step_sync(); guard++;
            end
            chk("R9", disp_en, 3'b111);
        end
        run(200);
        // directed: turning two layers off is immediate (R10)
        @(negedge clk); c_req = 3'b001; cfg_wr = 1; step_sync();
        @(negedge clk); cfg_wr = 0; step_sync();
        chk("R10", disp_en & 3'b110, 0);

        // every control combination, random sync waveforms (R2..R8)
        for (int s = 0; s < 16; s++) begin
            write_cfg(4'(s), L'($urandom));
            run(2500);
        end
        // directed delayed mode check with the sense active high (R6)
        write_cfg(4'b1111, 3'b010);
        run(3000);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule